// File: doc/BRIEF.md
# RAM Access Sequencer with Microcode Read Port

This block turns processor bus requests into accesses to a 3.5 KB on-chip RAM that is organised as 16-bit words. A request is a byte, a word or a long word. Each word-sized bus cycle takes two clocks. A long word is split into two such cycles, and the word at the lower address is handled first. The block drives the byte-lane write enables of the array and answers each request with a one-clock ready pulse or a one-clock address-error pulse. It also decides what happens when a synchronous reset request arrives partway through an access.

An external decoder works out whether an address belongs to the array. It presents only requests that hit, as a byte offset into the array. Three inputs lock the processor out of the array: the stop setting, the standby-supply indication and the emulation mode. While emulation mode is high, a separate read-only port gives a coprocessor the array contents, with a fixed latency of one clock.

Top module: `ram_access_seq`

## Requirements
- R1: A byte or word request (size code 0 = byte, 1 = word) that is accepted in clock c produces `cpu_ready` high in clock c+2 only. A word read returns the stored word in `cpu_rdata[15:0]` with the upper bits zero.
- R2: A long-word request (size code 2) at offset n runs two word cycles and raises `cpu_ready` in clock c+4 only. The word at offset n carries data bits [31:16] and the word at n+2 carries bits [15:0]. Within each word, the even byte is the upper lane.
- R3: A byte write changes only the addressed lane: an even offset writes word bits [15:8] and an odd offset writes bits [7:0], taking the data from `req_wdata[7:0]`. A byte read returns that lane in `cpu_rdata[7:0]` with the upper bits zero.
- R4: A word or long request at an odd offset, or any request with size code 3, leaves the array unchanged. It raises `cpu_addr_err` for exactly clock c+1 and never raises `cpu_ready`.
- R5: If `sync_rst` goes high during a byte or word access, the access still completes normally.
- R6: If `sync_rst` is high in clock c+1 or c+2 of a long access, only the first word is completed. `cpu_ready` goes high in clock c+2, a read returns the first word in [31:16] with zeros in [15:0], and the word at n+2 is not written.
- R7: If `sync_rst` is high in clock c+3 or c+4 of a long access, the whole long word completes.
- R8: A request presented in a clock in which `sync_rst` is high is ignored.
- R9: While `stop_mode` or `standby_pwr` is high, requests are ignored: there is no ready, no error and no change to the array.
- R10: While `emu_mode` is high, processor requests are ignored, and `emu_rdata` shows the word at word index `emu_addr` one clock after that index is presented. While `emu_mode` is low, `emu_rdata` is zero.
- R11: A request whose last byte would lie at or beyond offset 3584 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sync_rst | input | 1 | Synchronous reset request |
| req_valid | input | 1 | Request strobe for one clock, sampled when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 long, 3 invalid |
| req_addr | input | 12 | Byte offset into the array |
| req_wdata | input | 32 | Write data, right-aligned |
| cpu_ready | output | 1 | Access completion pulse |
| cpu_addr_err | output | 1 | Address-error pulse |
| cpu_rdata | output | 32 | Read data, valid while ready is high on a read |
| stop_mode | input | 1 | Array stopped, access blocked |
| standby_pwr | input | 1 | Array running from standby supply, access blocked |
| emu_mode | input | 1 | Array handed to the microcode port |
| emu_addr | input | 11 | Microcode port word index |
| emu_rdata | output | 16 | Microcode port read data |

## Verification
The awkward overlap is a synchronous reset request landing in the same clock as one of the word cycles of a long access. The bench pulses `sync_rst` in each clock from the request clock through the fourth clock of long reads and long writes. It judges the ready clock and the returned data against a byte-level model of the array. It then reads the second word back to see whether it was written. The microcode port is sampled while a processor write is being refused, and the same location is read back afterwards to confirm that the write never reached the array.

// File: rtl/ram_seq_pkg.sv
package ram_seq_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W0A,
    ST_W0B,
    ST_W1A,
    ST_W1B,
    ST_ERR
  } seq_state_e;

  // number of bytes a request spans
  function automatic int unsigned size_bytes(logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: return 1;
      SZ_WORD: return 2;
      default: return 4;
    endcase
  endfunction

  // word and long requests must start on an even offset; size code 3 is never legal
  function automatic logic misaligned(logic [1:0] sz, logic lsb);
    return (acc_size_e'(sz) == SZ_BAD) || ((acc_size_e'(sz) != SZ_BYTE) && lsb);
  endfunction

  // true when every byte of the request lies inside the array
  function automatic logic fits(logic [31:0] addr, logic [1:0] sz, int unsigned limit);
    return (addr + size_bytes(sz)) <= limit;
  endfunction

  // bit 1 = upper lane [15:8], bit 0 = lower lane [7:0]
  function automatic logic [1:0] lane_mask(logic [1:0] sz, logic lsb);
    if (acc_size_e'(sz) == SZ_BYTE) return lsb ? 2'b01 : 2'b10;
    return 2'b11;
  endfunction

endpackage

// File: rtl/rsq_array.sv
module rsq_array #(
  parameter int WORDS = 1792,
  parameter int WAW   = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_mask,
  input  logic [WAW-1:0] wr_idx,
  input  logic [15:0]    wr_word,
  input  logic [WAW-1:0] rd_idx,
  output logic [15:0]    rd_word,
  input  logic           emu_en,
  input  logic [WAW-1:0] emu_idx,
  output logic [15:0]    emu_word
);

  logic [15:0] mem [WORDS];

  wire wr_in_rng  = int'(wr_idx)  < WORDS;
  wire rd_in_rng  = int'(rd_idx)  < WORDS;
  wire emu_in_rng = int'(emu_idx) < WORDS;

  always_ff @(posedge clk) begin
    if (wr_en && wr_in_rng) begin
      for (int b = 0; b < 2; b++) begin
        if (wr_mask[b]) mem[wr_idx][b*8 +: 8] <= wr_word[b*8 +: 8];
      end
    end
    rd_word <= rd_in_rng ? mem[rd_idx] : 16'h0000;
  end

  // dedicated read port, fixed one-clock latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  emu_word <= 16'h0000;
    else if (emu_en && emu_in_rng) emu_word <= mem[emu_idx];
    else                         emu_word <= 16'h0000;
  end

endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
  import ram_seq_pkg::*;
#(
  parameter int AW    = 12,
  parameter int BYTES = 3584
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_rst,
  input  logic          req_valid,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic          gate,
  output seq_state_e    state_o,
  output logic          acc_go,
  output logic          acc_err,
  output logic          ready,
  output logic          addr_err,
  output logic          busy,
  output logic          second_a
);

  seq_state_e st, st_nx;
  logic       long_q;
  logic       cut_q;
  logic       cut_now;

  wire in_range = fits({{(32-AW){1'b0}}, req_addr}, req_size, BYTES);
  wire accept   = req_valid && (st == ST_IDLE) && !gate && !sync_rst && in_range;

  assign acc_err = accept && misaligned(req_size, req_addr[0]);
  assign acc_go  = accept && !acc_err;
  // a long access is cut short when reset shows up in either clock of its first word
  assign cut_now = long_q && (cut_q || sync_rst);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE: if (acc_go) st_nx = ST_W0A; else if (acc_err) st_nx = ST_ERR;
      ST_W0A:  st_nx = ST_W0B;
      ST_W0B:  st_nx = (long_q && !cut_now) ? ST_W1A : ST_IDLE;
      ST_W1A:  st_nx = ST_W1B;
      ST_W1B:  st_nx = ST_IDLE;
      ST_ERR:  st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      long_q <= 1'b0;
      cut_q  <= 1'b0;
    end else begin
      st <= st_nx;
      if (acc_go) begin
        long_q <= (acc_size_e'(req_size) == SZ_LONG);
        cut_q  <= 1'b0;
      end else if (st == ST_W0A && sync_rst) begin
        cut_q  <= 1'b1;
      end
    end
  end

  assign state_o  = st;
  assign ready    = ((st == ST_W0B) && (!long_q || cut_now)) || (st == ST_W1B);
  assign addr_err = (st == ST_ERR);
  assign busy     = (st != ST_IDLE);
  assign second_a = (st == ST_W1A);

endmodule

// File: rtl/rsq_lane.sv
module rsq_lane
  import ram_seq_pkg::*;
#(
  parameter int AW  = 12,
  parameter int WAW = AW - 1
) (
  input  logic [AW-1:0]  addr_q,
  input  logic [1:0]     size_q,
  input  logic           second,
  input  logic [31:0]    wdata_q,
  input  logic [15:0]    rd_word,
  input  logic [15:0]    hold_hi,
  output logic [WAW-1:0] idx,
  output logic [1:0]     mask,
  output logic [15:0]    wr_word,
  output logic [31:0]    rdata
);

  logic [7:0] lane_byte [2];

  assign idx  = addr_q[AW-1:1] + {{(WAW-1){1'b0}}, second};
  assign mask = lane_mask(size_q, addr_q[0]);

  for (genvar b = 0; b < 2; b++) begin : g_lane
    assign lane_byte[b] = rd_word[b*8 +: 8];
  end

  always_comb begin
    case (acc_size_e'(size_q))
      SZ_BYTE: wr_word = {wdata_q[7:0], wdata_q[7:0]};
      SZ_LONG: wr_word = second ? wdata_q[15:0] : wdata_q[31:16];
      default: wr_word = wdata_q[15:0];
    endcase
  end

  always_comb begin
    case (acc_size_e'(size_q))
      SZ_BYTE: rdata = {24'h0, addr_q[0] ? lane_byte[0] : lane_byte[1]};
      SZ_LONG: rdata = second ? {hold_hi, rd_word} : {rd_word, 16'h0000};
      default: rdata = {16'h0000, rd_word};
    endcase
  end

endmodule

// File: rtl/ram_access_seq.sv
module ram_access_seq
  import ram_seq_pkg::*;
#(
  parameter int BYTES = 3584,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          cpu_ready,
  output logic          cpu_addr_err,
  output logic [31:0]   cpu_rdata,
  input  logic          stop_mode,
  input  logic          standby_pwr,
  input  logic          emu_mode,
  input  logic [AW-2:0] emu_addr,
  output logic [15:0]   emu_rdata
);

  localparam int WORDS = BYTES / 2;
  localparam int WAW   = AW - 1;

  seq_state_e     st;
  logic           acc_go, acc_err, busy, second_a;
  logic [AW-1:0]  addr_q;
  logic [1:0]     size_q;
  logic           wr_q;
  logic [31:0]    wdata_q;
  logic [15:0]    hold_hi;
  logic [15:0]    rd_word;
  logic [WAW-1:0] idx;
  logic [1:0]     mask;
  logic [15:0]    wr_word;
  logic [31:0]    rdata_asm;

  wire gate    = emu_mode || stop_mode || standby_pwr;
  wire second  = (st == ST_W1A) || (st == ST_W1B);
  wire data_ph = (st == ST_W0B) || (st == ST_W1B);
  wire wr_en   = data_ph && wr_q;

  rsq_fsm #(.AW(AW), .BYTES(BYTES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sync_rst(sync_rst),
    .req_valid(req_valid), .req_size(req_size), .req_addr(req_addr), .gate(gate),
    .state_o(st), .acc_go(acc_go), .acc_err(acc_err),
    .ready(cpu_ready), .addr_err(cpu_addr_err), .busy(busy), .second_a(second_a)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      size_q  <= 2'd0;
      wr_q    <= 1'b0;
      wdata_q <= 32'h0;
      hold_hi <= 16'h0;
    end else begin
      if (acc_go) begin
        addr_q  <= req_addr;
        size_q  <= req_size;
        wr_q    <= req_write;
        wdata_q <= req_wdata;
      end
      if (st == ST_W0B) hold_hi <= rd_word;
    end
  end

  rsq_lane #(.AW(AW), .WAW(WAW)) u_lane (
    .addr_q(addr_q), .size_q(size_q), .second(second), .wdata_q(wdata_q),
    .rd_word(rd_word), .hold_hi(hold_hi),
    .idx(idx), .mask(mask), .wr_word(wr_word), .rdata(rdata_asm)
  );

  rsq_array #(.WORDS(WORDS), .WAW(WAW)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_mask(mask), .wr_idx(idx), .wr_word(wr_word),
    .rd_idx(idx), .rd_word(rd_word),
    .emu_en(emu_mode), .emu_idx(emu_addr), .emu_word(emu_rdata)
  );

  assign cpu_rdata = (cpu_ready && !wr_q) ? rdata_asm : 32'h0;

endmodule

// File: rtl/ram_access_seq_chk.sv
module ram_access_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_rst,
  input logic [1:0] req_size,
  input logic       stop_mode,
  input logic       standby_pwr,
  input logic       emu_mode,
  input logic       acc_go,
  input logic       acc_err,
  input logic       busy,
  input logic       second_a,
  input logic       cpu_ready,
  input logic       cpu_addr_err,
  input logic [15:0] emu_rdata
);

  // R1: short access answers in the second clock after acceptance
  a_r1_short_ready: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go && (req_size != 2'd2) |=> !cpu_ready ##1 cpu_ready);

  a_r1_ready_not_err: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !cpu_addr_err);

  // R4: error pulse follows a refused request for one clock
  a_r4_err_next: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> cpu_addr_err && !cpu_ready);

  a_r4_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr_err |=> !cpu_addr_err);

  // R7: once the second word has begun it always completes
  a_r7_second_done: assert property (@(posedge clk) disable iff (!rst_n)
    second_a |=> cpu_ready);

  // R8: no request starts in a reset clock
  a_r8_rst_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rst && !busy |=> !busy);

  // R9 / R10: lockout inputs keep the sequencer idle
  a_r9_locked_out: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode || standby_pwr || emu_mode) && !busy |=> !busy);

  // R10: microcode port is quiet outside emulation
  a_r10_emu_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !emu_mode |=> emu_rdata == 16'h0000);

endmodule

bind ram_access_seq ram_access_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_rst(sync_rst), .req_size(req_size),
  .stop_mode(stop_mode), .standby_pwr(standby_pwr), .emu_mode(emu_mode),
  .acc_go(acc_go), .acc_err(acc_err), .busy(busy), .second_a(second_a),
  .cpu_ready(cpu_ready), .cpu_addr_err(cpu_addr_err), .emu_rdata(emu_rdata)
);

// File: tb/ram_access_seq_tb.sv
`timescale 1ns/1ps
module ram_access_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_rst = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [11:0] req_addr = 12'h0;
  logic [31:0] req_wdata = 32'h0;
  logic        cpu_ready, cpu_addr_err;
  logic [31:0] cpu_rdata;
  logic        stop_mode = 1'b0, standby_pwr = 1'b0, emu_mode = 1'b0;
  logic [10:0] emu_addr = 11'h0;
  logic [15:0] emu_rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mdl [4096];

  always #4 clk = ~clk;

  ram_access_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sync_rst(sync_rst),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .cpu_ready(cpu_ready), .cpu_addr_err(cpu_addr_err), .cpu_rdata(cpu_rdata),
    .stop_mode(stop_mode), .standby_pwr(standby_pwr), .emu_mode(emu_mode),
    .emu_addr(emu_addr), .emu_rdata(emu_rdata)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One request, checked clock by clock against the byte model.
  // rst_at: clock index (0 = request clock) in which sync_rst is pulsed, -1 for none.
  task automatic access(string tag, logic wr, logic [1:0] sz, int a, logic [31:0] wd, int rst_at);
    int nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    logic ign = emu_mode || stop_mode || standby_pwr || (rst_at == 0) || (a + nb > 3584);
    logic bad = !ign && ((sz == 2'd3) || (sz != 2'd0 && a[0]));
    logic trunc = (sz == 2'd2) && (rst_at == 1 || rst_at == 2);
    int last = (ign || bad) ? -1 : ((sz == 2'd2 && !trunc) ? 4 : 2);
    logic [31:0] exp_rd = 32'h0;
    if (!ign && !bad) begin
      case (sz)
        2'd0: exp_rd = {24'h0, mdl[a]};
        2'd1: exp_rd = {16'h0, mdl[a], mdl[a+1]};
        default: exp_rd = trunc ? {mdl[a], mdl[a+1], 16'h0} : {mdl[a], mdl[a+1], mdl[a+2], mdl[a+3]};
      endcase
    end
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      req_valid = (c == 0);
      req_write = wr;
      req_size  = sz;
      req_addr  = a[11:0];
      req_wdata = wd;
      sync_rst  = (c == rst_at);
      #1;
      chk(tag, "ready", {31'h0, cpu_ready}, {31'h0, c == last});
      chk(tag, "addr_err", {31'h0, cpu_addr_err}, {31'h0, bad && c == 1});
      if (c == last && !wr) chk(tag, "rdata", cpu_rdata, exp_rd);
    end
    sync_rst  = 1'b0;
    req_valid = 1'b0;
    if (wr && !ign && !bad) begin
      case (sz)
        2'd0: mdl[a] = wd[7:0];
        2'd1: begin mdl[a] = wd[15:8]; mdl[a+1] = wd[7:0]; end
        default: begin
          mdl[a] = wd[31:24]; mdl[a+1] = wd[23:16];
          if (!trunc) begin mdl[a+2] = wd[15:8]; mdl[a+3] = wd[7:0]; end
        end
      endcase
    end
  endtask

  task automatic emu_look(string tag, int widx);
    @(negedge clk);
    emu_addr = widx[10:0];
    @(negedge clk);
    #1;
    chk(tag, "emu_rdata", {16'h0, emu_rdata}, {16'h0, mdl[2*widx], mdl[2*widx+1]});
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    report();
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", "reset ready", {31'h0, cpu_ready}, 32'h0);
    chk("R4", "reset addr_err", {31'h0, cpu_addr_err}, 32'h0);
    chk("R10", "reset emu_rdata", {16'h0, emu_rdata}, 32'h0);

    // R2: long writes fill the regions used later, then read back in two orders
    access("R2", 1'b1, 2'd2, 12'h100, 32'h11223344, -1);
    access("R2", 1'b1, 2'd2, 12'h104, 32'h55667788, -1);
    access("R2", 1'b1, 2'd2, 12'h108, 32'h99AABBCC, -1);
    access("R2", 1'b1, 2'd2, 12'h10C, 32'hDDEEF011, -1);
    access("R2", 1'b1, 2'd2, 12'h110, 32'h2468ACE0, -1);
    access("R2", 1'b1, 2'd2, 12'hDFC, 32'hCAFEF00D, -1);
    access("R2", 1'b0, 2'd2, 12'h100, 32'h0, -1);
    access("R2", 1'b0, 2'd1, 12'h102, 32'h0, -1);
    access("R2", 1'b0, 2'd2, 12'hDFC, 32'h0, -1);

    // R3: byte lanes
    access("R3", 1'b1, 2'd0, 12'h105, 32'h000000AB, -1);
    access("R3", 1'b1, 2'd0, 12'h104, 32'h000000CD, -1);
    access("R3", 1'b0, 2'd1, 12'h104, 32'h0, -1);
    access("R3", 1'b0, 2'd0, 12'h101, 32'h0, -1);
    access("R3", 1'b0, 2'd0, 12'h100, 32'h0, -1);

    // R1: word write and read
    access("R1", 1'b1, 2'd1, 12'h108, 32'h0000BEEF, -1);
    access("R1", 1'b0, 2'd1, 12'h108, 32'h0, -1);
    access("R1", 1'b0, 2'd2, 12'h106, 32'h0, -1);

    // R4: misaligned and invalid size leave the array alone
    access("R4", 1'b1, 2'd1, 12'h103, 32'h00001234, -1);
    access("R4", 1'b1, 2'd2, 12'h109, 32'h12345678, -1);
    access("R4", 1'b1, 2'd3, 12'h104, 32'h12345678, -1);
    access("R4", 1'b0, 2'd2, 12'h100, 32'h0, -1);
    access("R4", 1'b0, 2'd2, 12'h104, 32'h0, -1);
    access("R4", 1'b0, 2'd2, 12'h108, 32'h0, -1);

    // R5: reset inside a short access
    access("R5", 1'b1, 2'd1, 12'h10A, 32'h00005A5A, 1);
    access("R5", 1'b0, 2'd0, 12'h10B, 32'h0, 2);
    access("R5", 1'b0, 2'd1, 12'h10A, 32'h0, -1);

    // R6: reset inside the first word of a long access
    access("R6", 1'b1, 2'd2, 12'h10C, 32'hA1B2C3D4, 1);
    access("R6", 1'b0, 2'd2, 12'h10C, 32'h0, -1);
    access("R6", 1'b1, 2'd2, 12'h110, 32'h0F1E2D3C, 2);
    access("R6", 1'b0, 2'd2, 12'h110, 32'h0, -1);
    access("R6", 1'b0, 2'd2, 12'h100, 32'h0, 2);
    access("R6", 1'b0, 2'd2, 12'h104, 32'h0, 1);

    // R7: reset inside the second word
    access("R7", 1'b1, 2'd2, 12'h10C, 32'h31415926, 3);
    access("R7", 1'b1, 2'd2, 12'h110, 32'h27182818, 4);
    access("R7", 1'b0, 2'd2, 12'h10C, 32'h0, 4);
    access("R7", 1'b0, 2'd2, 12'h110, 32'h0, 3);

    // R8: request in the reset clock
    access("R8", 1'b1, 2'd1, 12'h100, 32'h0000FFFF, 0);
    access("R8", 1'b0, 2'd1, 12'h100, 32'h0, -1);

    // R9: stop and standby lockout
    stop_mode = 1'b1;
    access("R9", 1'b1, 2'd2, 12'h100, 32'hDEADBEEF, -1);
    stop_mode = 1'b0;
    standby_pwr = 1'b1;
    access("R9", 1'b1, 2'd0, 12'h101, 32'h00000077, -1);
    standby_pwr = 1'b0;
    access("R9", 1'b0, 2'd2, 12'h100, 32'h0, -1);

    // R11: requests that run past the array end
    access("R11", 1'b1, 2'd2, 12'hDFE, 32'h01020304, -1);
    access("R11", 1'b1, 2'd0, 12'hE00, 32'h00000055, -1);
    access("R11", 1'b0, 2'd2, 12'hDFC, 32'h0, -1);

    // R10: microcode port takes over the array
    emu_mode = 1'b1;
    emu_look("R10", 12'h100 >> 1);
    emu_look("R10", 12'h10C >> 1);
    emu_look("R10", 12'hDFE >> 1);
    access("R10", 1'b1, 2'd1, 12'h104, 32'h00001111, -1);
    emu_look("R10", 12'h104 >> 1);
    @(negedge clk);
    emu_mode = 1'b0;
    @(negedge clk);
    #1;
    chk("R10", "emu_rdata off", {16'h0, emu_rdata}, 32'h0);
    access("R10", 1'b0, 2'd1, 12'h104, 32'h0, -1);

    report();
    $finish;
  end

endmodule